// File: doc/BRIEF.md
# Virtual Data Plane Header Tagger

This block sits at the entry of a packet pipeline. It sorts each incoming Ethernet frame into one of several virtual data planes, so that frames meant for different planes move through isolated processing paths. The first beat of each frame carries the destination MAC address. The block matches this address against a small table that software programs, and the match yields a plane number.

For every matched frame, the block sends out one 64-bit control header and then the unchanged frame. The header holds a hash field, which is left zero here for a later hashing stage to fill, a module-enable bitmap, a forwarding mode and the plane number. The bitmap and the mode come from a register pair kept for each plane. A frame whose address matches no table entry is consumed and discarded, and a miss counter advances by one.

Both stream sides use valid/ready handshakes. A beat moves only in a cycle where valid and ready are both high. While `out_valid` is high and `out_ready` is low, the output beat and its markers hold still. The input is stalled only while the block cannot store another beat. A frame costs one extra output cycle, which carries the header.

Top module: `vdp_header_tagger`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `miss_count` is 0.
- R2: The lookup key is `in_data[63:16]` of the accepted beat that has `in_sop` high. It is compared with every valid table entry. When several entries match, the entry with the lowest index supplies the plane number.
- R3: A matched frame leaves as one header beat (`out_sop`=1, `out_eop`=0), then every input beat in order with unchanged data (`out_sop`=0). `out_eop` is 1 only on the last of these beats.
- R4: Header layout: bits 63:32 are the hash field and are always zero. Bits 31:16 are the bitmap, bits 15:8 the mode, and bits 7:0 the zero-extended plane number.
- R5: The bitmap and mode are taken from the plane's registers in the cycle the start beat is accepted. Later writes to those registers do not change a header that is already pending.
- R6: A frame with no matching entry produces no output beat. All of its beats are accepted without stall, and `miss_count` increases by exactly one. The counter wraps.
- R7: An entry written with bit 63 = 0, or with a plane number (bits 62:48) of at least the plane count, never matches.
- R8: While `out_valid`=1 and `out_ready`=0, the output data and markers stay stable in the next cycle. No beat is lost or repeated under any stall pattern, and `in_ready` is 0 while the header is pending.
- R9: Beats that arrive outside a frame with `in_sop`=0 are accepted and discarded. They produce no output and do not change `miss_count`.
- R10: Configuration: a write with `cfg_we`=1 and `cfg_addr[4]`=0 sets table entry `cfg_addr[3:0]` to MAC `cfg_wdata[47:0]`, plane `cfg_wdata[62:48]`, valid `cfg_wdata[63]`. A write with `cfg_addr[4]`=1 sets plane `cfg_addr[3:0]` to bitmap `cfg_wdata[15:0]` and mode `cfg_wdata[23:16]`. A write takes effect from the next cycle.
- R11: The header beat is valid in the cycle right after the start beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 64 | Input beat data |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_data | output | 64 | Output beat data (header or frame) |
| out_sop | output | 1 | Header beat marker |
| out_eop | output | 1 | Last frame beat marker |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Table entry or plane register select |
| cfg_wdata | input | 64 | Configuration write data |
| miss_count | output | 16 | Count of frames dropped on lookup miss |

## Verification
Lookups are tried with addresses that hit a single entry, with addresses that hit two entries, and with addresses that hit only a cleared entry or one carrying an out-of-range plane. Together these separate the priority order, the valid qualification and the plane-range check. Frames are sent with the output always ready, fully stalled while a header is pending, and stalled on a repeating pattern with frames back to back. This separates the header timing, the holding of data under a stall, and the framing across frame boundaries. Stray beats outside any frame, and register writes made while a header waits, show that neither one leaks into the output.

// File: rtl/vdp_tag_pkg.sv
package vdp_tag_pkg;

  localparam int BEAT_W = 64;
  localparam int MAC_W  = 48;

  // Control header sent ahead of each accepted frame (MSB first)
  typedef struct packed {
    logic [31:0] hash;
    logic [15:0] bitmap;
    logic [7:0]  mode;
    logic [7:0]  plane;
  } vdp_hdr_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_BODY,
    ST_DROP
  } vdp_state_e;

endpackage

// File: rtl/vdp_mac_cam.sv
module vdp_mac_cam #(
  parameter int N_ENTRIES = 16,
  parameter int PID_W     = 2,
  localparam int EIDX_W   = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [EIDX_W-1:0] wr_idx,
  input  logic [47:0]       wr_mac,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic              wr_valid,
  input  logic [47:0]       lookup_mac,
  output logic              hit,
  output logic [PID_W-1:0]  hit_pid
);

  logic [47:0]      mac_q [N_ENTRIES];
  logic [PID_W-1:0] pid_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] vld_q;
  logic [N_ENTRIES-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
        mac_q[i] <= '0;
        pid_q[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (wr_idx == EIDX_W'(i)) begin
          mac_q[i] <= wr_mac;
          pid_q[i] <= wr_pid;
          vld_q[i] <= wr_valid;
        end
      end
    end
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (mac_q[g] == lookup_mac);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    hit     = 1'b0;
    hit_pid = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_pid = pid_q[i];
      end
    end
  end

endmodule

// File: rtl/vdp_plane_ctrl.sv
module vdp_plane_ctrl #(
  parameter int N_PLANES = 4,
  parameter int IDX_W    = 4,
  localparam int PID_W   = (N_PLANES > 1) ? $clog2(N_PLANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [15:0]      wr_bitmap,
  input  logic [7:0]       wr_mode,
  input  logic [PID_W-1:0] rd_pid,
  output logic [15:0]      rd_bitmap,
  output logic [7:0]       rd_mode
);

  logic [15:0] bitmap_q [N_PLANES];
  logic [7:0]  mode_q   [N_PLANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N_PLANES; p++) begin
        bitmap_q[p] <= '0;
        mode_q[p]   <= '0;
      end
    end else if (wr_en) begin
      for (int p = 0; p < N_PLANES; p++) begin
        if (wr_idx == IDX_W'(p)) begin
          bitmap_q[p] <= wr_bitmap;
          mode_q[p]   <= wr_mode;
        end
      end
    end
  end

  always_comb begin
    rd_bitmap = '0;
    rd_mode   = '0;
    for (int p = 0; p < N_PLANES; p++) begin
      if (rd_pid == PID_W'(p)) begin
        rd_bitmap = bitmap_q[p];
        rd_mode   = mode_q[p];
      end
    end
  end

endmodule

// File: rtl/vdp_stream_core.sv
module vdp_stream_core
  import vdp_tag_pkg::*;
#(
  parameter int PID_W = 2,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [MAC_W-1:0]  lookup_mac,
  input  logic              hit,
  input  logic [PID_W-1:0]  hit_pid,
  input  logic [15:0]       sel_bitmap,
  input  logic [7:0]        sel_mode,
  output logic [CNT_W-1:0]  miss_count
);

  vdp_state_e        state_q;
  vdp_hdr_t          hdr_q, hdr_d;
  logic [BEAT_W-1:0] hold_q;
  logic              hold_v_q, hold_eop_q, eop_in_q;
  logic [CNT_W-1:0]  miss_q;
  logic              in_fire, out_fire;

  assign lookup_mac = in_data[BEAT_W-1 -: MAC_W];
  assign miss_count = miss_q;
  assign in_fire    = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;

  always_comb begin
    hdr_d        = '0;
    hdr_d.bitmap = sel_bitmap;
    hdr_d.mode   = sel_mode;
    hdr_d.plane  = 8'(hit_pid);
  end

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    out_data  = hold_q;
    unique case (state_q)
      ST_IDLE: in_ready = 1'b1;
      ST_HDR: begin
        out_valid = 1'b1;
        out_sop   = 1'b1;
        out_data  = hdr_q;
      end
      ST_BODY: begin
        out_valid = hold_v_q;
        out_eop   = hold_v_q && hold_eop_q;
        in_ready  = !eop_in_q && (!hold_v_q || out_ready);
      end
      ST_DROP: in_ready = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      hdr_q      <= '0;
      hold_q     <= '0;
      hold_v_q   <= 1'b0;
      hold_eop_q <= 1'b0;
      eop_in_q   <= 1'b0;
      miss_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_fire && in_sop) begin
            if (hit) begin
              hdr_q      <= hdr_d;
              hold_q     <= in_data;
              hold_v_q   <= 1'b1;
              hold_eop_q <= in_eop;
              eop_in_q   <= in_eop;
              state_q    <= ST_HDR;
            end else begin
              miss_q <= miss_q + CNT_W'(1);
              if (!in_eop) state_q <= ST_DROP;
            end
          end
        end
        ST_HDR: begin
          if (out_ready) state_q <= ST_BODY;
        end
        ST_BODY: begin
          if (out_fire && hold_eop_q) begin
            state_q  <= ST_IDLE;
            hold_v_q <= 1'b0;
            eop_in_q <= 1'b0;
          end else if (in_fire) begin
            hold_q     <= in_data;
            hold_v_q   <= 1'b1;
            hold_eop_q <= in_eop;
            if (in_eop) eop_in_q <= 1'b1;
          end else if (out_fire) begin
            hold_v_q <= 1'b0;
          end
        end
        ST_DROP: begin
          if (in_fire && in_eop) state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/vdp_header_tagger.sv
module vdp_header_tagger
  import vdp_tag_pkg::*;
#(
  parameter int N_PLANES  = 4,
  parameter int N_ENTRIES = 16,
  parameter int CNT_W     = 16,
  localparam int PID_W    = (N_PLANES > 1) ? $clog2(N_PLANES) : 1,
  localparam int EIDX_W   = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int IDX_W    = (EIDX_W > PID_W) ? EIDX_W : PID_W,
  localparam int ADDR_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [63:0]       out_data,
  output logic              out_sop,
  output logic              out_eop,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [63:0]       cfg_wdata,
  output logic [CNT_W-1:0]  miss_count
);

  logic             cam_we, ctl_we, entry_ok;
  logic [47:0]      lookup_mac;
  logic             hit;
  logic [PID_W-1:0] hit_pid;
  logic [15:0]      sel_bitmap;
  logic [7:0]       sel_mode;

  assign cam_we   = cfg_we && !cfg_addr[ADDR_W-1];
  assign ctl_we   = cfg_we &&  cfg_addr[ADDR_W-1];
  // An entry naming a plane that does not exist is stored as invalid
  assign entry_ok = cfg_wdata[63] && (cfg_wdata[62:48] < 15'(N_PLANES));

  vdp_mac_cam #(
    .N_ENTRIES(N_ENTRIES),
    .PID_W    (PID_W)
  ) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cam_we),
    .wr_idx    (cfg_addr[EIDX_W-1:0]),
    .wr_mac    (cfg_wdata[47:0]),
    .wr_pid    (cfg_wdata[48 +: PID_W]),
    .wr_valid  (entry_ok),
    .lookup_mac(lookup_mac),
    .hit       (hit),
    .hit_pid   (hit_pid)
  );

  vdp_plane_ctrl #(
    .N_PLANES(N_PLANES),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_we),
    .wr_idx   (cfg_addr[IDX_W-1:0]),
    .wr_bitmap(cfg_wdata[15:0]),
    .wr_mode  (cfg_wdata[23:16]),
    .rd_pid   (hit_pid),
    .rd_bitmap(sel_bitmap),
    .rd_mode  (sel_mode)
  );

  vdp_stream_core #(
    .PID_W(PID_W),
    .CNT_W(CNT_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .lookup_mac(lookup_mac),
    .hit       (hit),
    .hit_pid   (hit_pid),
    .sel_bitmap(sel_bitmap),
    .sel_mode  (sel_mode),
    .miss_count(miss_count)
  );

endmodule

// File: rtl/vdp_header_tagger_chk.sv
module vdp_header_tagger_chk #(
  parameter int N_PLANES = 4,
  parameter int CNT_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [63:0]      out_data,
  input logic             out_sop,
  input logic             out_eop,
  input logic [CNT_W-1:0] miss_count
);

  logic frame_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_open <= 1'b0;
    else if (out_valid && out_ready) begin
      if (out_eop)      frame_open <= 1'b0;
      else if (out_sop) frame_open <= 1'b1;
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  a_r4_hash_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> out_data[63:32] == 32'h0);

  a_r4_plane_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> out_data[7:0] < 8'(N_PLANES));

  a_r3_header_first: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !frame_open |-> out_sop && !out_eop);

  a_r3_no_sop_inside: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && frame_open |-> !out_sop);

  a_r6_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + CNT_W'(1)));

endmodule

bind vdp_header_tagger vdp_header_tagger_chk #(
  .N_PLANES(N_PLANES),
  .CNT_W   (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .miss_count(miss_count)
);

// File: tb/vdp_header_tagger_tb.sv
module vdp_header_tagger_tb;

  localparam int N_PLANES  = 4;
  localparam int N_ENTRIES = 16;
  localparam int CNT_W     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ready;
  logic        out_valid, out_sop, out_eop;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic [CNT_W-1:0] miss_count;

  vdp_header_tagger #(
    .N_PLANES(N_PLANES), .N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .miss_count(miss_count)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  bit stall_all = 1'b0;
  bit bp_on = 1'b0;
  always @(negedge clk) out_ready = !stall_all && (!bp_on || (cyc % 3 != 0));

  logic [65:0] q[$];
  always @(posedge clk)
    if (rst_n && out_valid && out_ready) q.push_back({out_sop, out_eop, out_data});

  int n_chk = 0, n_fail = 0;

  localparam logic [47:0] MAC_A = 48'h0011_2233_4455;
  localparam logic [47:0] MAC_B = 48'h0A0B_0C0D_0E0F;
  localparam logic [47:0] MAC_C = 48'h0200_0000_0003;
  localparam logic [47:0] MAC_D = 48'h0600_1111_2222;
  localparam logic [47:0] MAC_F = 48'h0E00_7777_8888;
  localparam logic [47:0] MAC_X = 48'hDEAD_BEEF_0001;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] beat(input logic [47:0] mac, input logic [15:0] tag, input int i);
    return (i == 0) ? {mac, tag} : {tag, 16'h0, 32'(i)};
  endfunction

  function automatic logic [63:0] hdr(input logic [15:0] bm, input logic [7:0] md, input int pid);
    return {32'h0, bm, md, 8'(pid)};
  endfunction

  task automatic cfg_write(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic mac_entry(input int idx, input logic [47:0] mac, input int pid, input bit vld);
    cfg_write({1'b0, 4'(idx)}, {vld, 15'(pid), mac});
  endtask

  task automatic plane_ctrl(input int p, input logic [15:0] bm, input logic [7:0] md);
    cfg_write({1'b1, 4'(p)}, {40'h0, md, bm});
  endtask

  task automatic send(input logic [47:0] mac, input logic [15:0] tag, input int n, output int stalls);
    stalls = 0;
    for (int i = 0; i < n; ) begin
      bit fired;
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == n - 1);
      in_data = beat(mac, tag, i);
      #1 fired = in_ready;
      @(posedge clk);
      if (fired) i++; else stalls++;
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic expect_frame(input int ofs, input logic [47:0] mac, input logic [15:0] tag,
                              input int n, input logic [63:0] h, input string req);
    chk(q.size() >= ofs + n + 1, req, "beat count", 64'(q.size()), 64'(ofs + n + 1));
    if (q.size() >= ofs + n + 1) begin
      chk(q[ofs] == {2'b10, h}, req, "header beat", q[ofs][63:0], h);
      for (int i = 0; i < n; i++)
        chk(q[ofs+1+i] == {1'b0, (i == n - 1), beat(mac, tag, i)}, req, "frame beat",
            q[ofs+1+i][63:0], beat(mac, tag, i));
    end
  endtask

  task automatic drain();
    repeat (14) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    chk(miss_count == '0, "R1", "miss_count after reset", 64'(miss_count), 64'd0);
  endtask

  task automatic t_basic();
    int st;
    plane_ctrl(0, 16'h0001, 8'h10);
    plane_ctrl(1, 16'h00F3, 8'h21);
    plane_ctrl(2, 16'hA5A5, 8'h02);
    plane_ctrl(3, 16'hFFFF, 8'h7E);
    mac_entry(0, MAC_A, 1, 1'b1);
    mac_entry(2, MAC_B, 2, 1'b1);
    mac_entry(5, MAC_C, 3, 1'b1);
    q.delete();
    send(MAC_A, 16'h1001, 3, st);
    drain();
    expect_frame(0, MAC_A, 16'h1001, 3, hdr(16'h00F3, 8'h21, 1), "R10 R4 R3 R2");
    q.delete();
    send(MAC_B, 16'h1002, 2, st);
    drain();
    expect_frame(0, MAC_B, 16'h1002, 2, hdr(16'hA5A5, 8'h02, 2), "R10 R4 R2");
    chk(q.size() == 3, "R3", "no extra beats", 64'(q.size()), 64'd3);
  endtask

  task automatic t_priority();
    int st;
    mac_entry(7, MAC_D, 3, 1'b1);
    mac_entry(9, MAC_D, 0, 1'b1);
    q.delete();
    send(MAC_D, 16'h2001, 2, st);
    drain();
    expect_frame(0, MAC_D, 16'h2001, 2, hdr(16'hFFFF, 8'h7E, 3), "R2 lowest index");
    mac_entry(7, MAC_D, 3, 1'b0);
    q.delete();
    send(MAC_D, 16'h2002, 2, st);
    drain();
    expect_frame(0, MAC_D, 16'h2002, 2, hdr(16'h0001, 8'h10, 0), "R7 cleared entry skipped");
  endtask

  task automatic t_miss();
    int st;
    logic [CNT_W-1:0] m0;
    @(negedge clk) m0 = miss_count;
    q.delete();
    send(MAC_X, 16'h3001, 4, st);
    drain();
    chk(st == 0, "R6", "stalls on dropped frame", 64'(st), 64'd0);
    chk(q.size() == 0, "R6", "output beats for miss", 64'(q.size()), 64'd0);
    @(negedge clk);
    chk(miss_count == m0 + 1'b1, "R6", "miss_count", 64'(miss_count), 64'(m0 + 1'b1));
    q.delete();
    send(MAC_X, 16'h3002, 1, st);
    drain();
    @(negedge clk);
    chk(q.size() == 0 && miss_count == m0 + 2'd2, "R6", "single-beat miss",
        64'(miss_count), 64'(m0 + 2'd2));
  endtask

  task automatic t_invalid();
    int st;
    logic [CNT_W-1:0] m0;
    mac_entry(11, MAC_F, 5, 1'b1);
    mac_entry(2, MAC_B, 2, 1'b0);
    @(negedge clk) m0 = miss_count;
    q.delete();
    send(MAC_F, 16'h4001, 2, st);
    send(MAC_B, 16'h4002, 2, st);
    drain();
    @(negedge clk);
    chk(q.size() == 0, "R7", "beats from invalid entries", 64'(q.size()), 64'd0);
    chk(miss_count == m0 + 2'd2, "R7", "misses counted", 64'(miss_count), 64'(m0 + 2'd2));
  endtask

  task automatic t_stray();
    int st;
    logic [CNT_W-1:0] m0;
    @(negedge clk) m0 = miss_count;
    q.delete();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == 1);
      in_data = {MAC_A, 16'(i)};
      #1 chk(in_ready == 1'b1, "R9", "stray beat accepted", 64'(in_ready), 64'd1);
    end
    @(negedge clk) in_valid = 1'b0;
    drain();
    @(negedge clk);
    chk(q.size() == 0, "R9", "stray output beats", 64'(q.size()), 64'd0);
    chk(miss_count == m0, "R9", "miss_count unchanged", 64'(miss_count), 64'(m0));
    send(MAC_A, 16'h5001, 2, st);
    drain();
    expect_frame(0, MAC_A, 16'h5001, 2, hdr(16'h00F3, 8'h21, 1), "R9 framing kept");
  endtask

  task automatic t_latency();
    q.delete();
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = beat(MAC_C, 16'h6001, 0);
    #1 chk(in_ready == 1'b1, "R11", "start beat taken", 64'(in_ready), 64'd1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid && out_sop, "R11", "header one cycle after start",
        {62'h0, out_valid, out_sop}, 64'd3);
    chk(out_data == hdr(16'hFFFF, 8'h7E, 3), "R11", "header data", out_data, hdr(16'hFFFF, 8'h7E, 3));
    drain();
    expect_frame(0, MAC_C, 16'h6001, 1, hdr(16'hFFFF, 8'h7E, 3), "R11 R3 single beat");
  endtask

  task automatic t_stall();
    int st;
    q.delete();
    stall_all = 1'b1;
    fork
      send(MAC_A, 16'h7001, 3, st);
      begin
        repeat (2) @(negedge clk);
        #2;
        chk(out_valid && out_sop && out_data == hdr(16'h00F3, 8'h21, 1), "R8", "header held",
            out_data, hdr(16'h00F3, 8'h21, 1));
        chk(in_ready == 1'b0, "R8", "in_ready while header pending", 64'(in_ready), 64'd0);
        plane_ctrl(1, 16'h1234, 8'h56);
        #2;
        chk(out_valid && out_data == hdr(16'h00F3, 8'h21, 1), "R5", "pending header unchanged",
            out_data, hdr(16'h00F3, 8'h21, 1));
        stall_all = 1'b0;
      end
    join
    drain();
    expect_frame(0, MAC_A, 16'h7001, 3, hdr(16'h00F3, 8'h21, 1), "R8 R5 old header");
    q.delete();
    send(MAC_A, 16'h7002, 2, st);
    drain();
    expect_frame(0, MAC_A, 16'h7002, 2, hdr(16'h1234, 8'h56, 1), "R5 new header");
  endtask

  task automatic t_bp_pattern();
    int st;
    q.delete();
    bp_on = 1'b1;
    send(MAC_A, 16'h8001, 5, st);
    send(MAC_C, 16'h8002, 3, st);
    send(MAC_D, 16'h8003, 1, st);
    repeat (30) @(posedge clk);
    bp_on = 1'b0;
    drain();
    chk(q.size() == 12, "R8", "total beats under stalls", 64'(q.size()), 64'd12);
    expect_frame(0, MAC_A, 16'h8001, 5, hdr(16'h1234, 8'h56, 1), "R8 frame 1");
    expect_frame(6, MAC_C, 16'h8002, 3, hdr(16'hFFFF, 8'h7E, 3), "R8 frame 2");
    expect_frame(10, MAC_D, 16'h8003, 1, hdr(16'h0001, 8'h10, 0), "R8 frame 3");
  endtask

  initial begin
    wait (cyc >= 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_basic();
    t_priority();
    t_miss();
    t_invalid();
    t_stray();
    t_latency();
    t_stall();
    t_bp_pattern();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule